// File: doc/BRIEF.md
# USB Bus-Event Interrupt Flag Register

This block holds the sticky interrupt flags that a USB device controller raises for bus-state changes: the start and the end of a host-driven bus reset, entry into suspend, return to resume, a point after suspend at which the controller clock may be gated, and a point at which the clock should run again. A one-cycle pulse from the line-state logic sets each flag. The flags stay set until software clears them through an 8-bit register write port.

Software reads the flags back on the same 8-bit bus. A written 0 clears a flag and a written 1 leaves it alone, so software clears a chosen flag by writing a word that is 1 everywhere except that bit. The block drives three outputs:

- an interrupt request, gated by a per-flag enable vector;
- an ungated wake request that releases the processor from either of the two lighter idle modes;
- a permission signal that allows the deeper idle mode only while the bus is suspended.

The clock-restart flag has two causes: a resume, or the start of a bus reset.

Top module: `usb_evt_flags`

## Requirements
- R1: While reset is asserted, and in the first cycle after it is released, all six flags are 0 and `rd_data` reads 8'h00.
- R2: A one-cycle pulse sets its flag at the next rising clock edge, at these fixed positions of `rd_data`:
  - bit 7: bus reset started
  - bit 6: bus reset ended
  - bit 5: suspend
  - bit 4: resume
  - bit 3: clock may stop
- R3: A write with `wr_en` high clears every flag whose bit in `wr_data` is 0, at the next edge.
- R4: A write of 1 to a flag bit leaves that flag unchanged.
- R5: Bits 1 and 0 of `rd_data` always read 0, and writing them has no effect.
- R6: The clock-on flag (bit 2) is set by a resume pulse, and also by a bus-reset-start pulse.
- R7: When a set pulse and a clearing write reach the same flag in the same cycle, the flag ends up set.
- R8: A set flag stays set while no clearing write targets it. This holds across cycles where `wr_en` is low, whatever `wr_data` carries.
- R9: `irq` is high exactly when some flag at register bit k+2 is 1 and `irq_en[k]` is 1, for k from 0 to 5.
- R10: `wake_req` is high exactly when any of the six flags is 1, independent of `irq_en`.
- R11: `deep_idle_ok` is high exactly when the suspend flag (bit 5) or the clock-stop flag (bit 3) is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| ev_rst_begin | input | 1 | Pulse: host bus reset reception started |
| ev_rst_done | input | 1 | Pulse: host bus reset ended |
| ev_suspend | input | 1 | Pulse: bus entered suspend |
| ev_resume | input | 1 | Pulse: bus entered resume |
| ev_clk_stop_ok | input | 1 | Pulse: clock may now be gated after suspend |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 8 | Write data; 0 bits clear flags |
| irq_en | input | 6 | Per-flag interrupt enable, bit k for register bit k+2 |
| rd_data | output | 8 | Flag readback |
| irq | output | 1 | Enabled-flag interrupt request |
| wake_req | output | 1 | Halt release request from lighter idle modes |
| deep_idle_ok | output | 1 | Deeper idle mode entry allowed |

## Verification
The bench builds the block with its default parameters: an 8-bit register, six flags starting at bit 2, and a two-stage reset release. With the two-stage release, the bench waits out the synchronizer before it sends the first event. The fixed register width puts every flag position, the two dead low bits and each one-hot enable pattern within reach of directed writes. It also exercises the collision of a set pulse with a clearing write on the same flag, and both causes of the clock-on flag.

// File: rtl/usb_evt_pkg.sv
package usb_evt_pkg;
  localparam int REG_W     = 8;
  localparam int NUM_FLAGS = 6;
  localparam int FLAG_LSB  = REG_W - NUM_FLAGS;

  // register bit positions (software decodes these)
  localparam int B_RST_BEGIN = 7;
  localparam int B_RST_DONE  = 6;
  localparam int B_SUSPEND   = 5;
  localparam int B_RESUME    = 4;
  localparam int B_CLK_STOP  = 3;
  localparam int B_CLK_ON    = 2;

  typedef struct packed {
    logic rst_begin;
    logic rst_done;
    logic suspend;
    logic resume;
    logic clk_stop_ok;
  } bus_evt_t;
endpackage

// File: rtl/usb_evt_rst_sync.sv
module usb_evt_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= '0;
    else         sync_q <= sync_d;
  end

  assign srst_n = sync_q[STAGES-1];
endmodule

// File: rtl/usb_evt_setmap.sv
module usb_evt_setmap
  import usb_evt_pkg::*;
(
  input  bus_evt_t               evt,
  output logic [NUM_FLAGS-1:0]   set_vec
);
  always_comb begin
    set_vec = '0;
    set_vec[B_RST_BEGIN - FLAG_LSB] = evt.rst_begin;
    set_vec[B_RST_DONE  - FLAG_LSB] = evt.rst_done;
    set_vec[B_SUSPEND   - FLAG_LSB] = evt.suspend;
    set_vec[B_RESUME    - FLAG_LSB] = evt.resume;
    set_vec[B_CLK_STOP  - FLAG_LSB] = evt.clk_stop_ok;
    // restart of the clock is wanted on resume and on bus reset start
    set_vec[B_CLK_ON    - FLAG_LSB] = evt.resume | evt.rst_begin;
  end
endmodule

// File: rtl/usb_evt_flag_cell.sv
module usb_evt_flag_cell (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_q
);
  logic flag_d;
  logic flag_en;

  // set wins over a simultaneous clear
  always_comb begin
    flag_en = set_i | clr_i;
    flag_d  = set_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       flag_q <= 1'b0;
    else if (flag_en) flag_q <= flag_d;
  end
endmodule

// File: rtl/usb_evt_outs.sv
module usb_evt_outs
  import usb_evt_pkg::*;
(
  input  logic [NUM_FLAGS-1:0] flags,
  input  logic [NUM_FLAGS-1:0] irq_en,
  output logic [REG_W-1:0]     rd_data,
  output logic                 irq,
  output logic                 wake_req,
  output logic                 deep_idle_ok
);
  always_comb begin
    rd_data      = {flags, {FLAG_LSB{1'b0}}};
    irq          = |(flags & irq_en);
    wake_req     = |flags;
    deep_idle_ok = flags[B_SUSPEND - FLAG_LSB] | flags[B_CLK_STOP - FLAG_LSB];
  end
endmodule

// File: rtl/usb_evt_flags.sv
module usb_evt_flags
  import usb_evt_pkg::*;
#(
  parameter int RST_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 ev_rst_begin,
  input  logic                 ev_rst_done,
  input  logic                 ev_suspend,
  input  logic                 ev_resume,
  input  logic                 ev_clk_stop_ok,
  input  logic                 wr_en,
  input  logic [REG_W-1:0]     wr_data,
  input  logic [NUM_FLAGS-1:0] irq_en,
  output logic [REG_W-1:0]     rd_data,
  output logic                 irq,
  output logic                 wake_req,
  output logic                 deep_idle_ok
);
  logic                 srst_n;
  bus_evt_t             evt;
  logic [NUM_FLAGS-1:0] set_vec;
  logic [NUM_FLAGS-1:0] clr_vec;
  logic [NUM_FLAGS-1:0] flags;

  usb_evt_rst_sync #(.STAGES(RST_STAGES)) u_rst_sync (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (srst_n)
  );

  always_comb begin
    evt.rst_begin   = ev_rst_begin;
    evt.rst_done    = ev_rst_done;
    evt.suspend     = ev_suspend;
    evt.resume      = ev_resume;
    evt.clk_stop_ok = ev_clk_stop_ok;
  end

  usb_evt_setmap u_setmap (
    .evt     (evt),
    .set_vec (set_vec)
  );

  // a written 0 clears; the low reserved bits go nowhere
  always_comb begin
    clr_vec = {NUM_FLAGS{wr_en}} & ~wr_data[REG_W-1:FLAG_LSB];
  end

  for (genvar k = 0; k < NUM_FLAGS; k++) begin : g_flag
    usb_evt_flag_cell u_cell (
      .clk    (clk),
      .rst_n  (srst_n),
      .set_i  (set_vec[k]),
      .clr_i  (clr_vec[k]),
      .flag_q (flags[k])
    );
  end

  usb_evt_outs u_outs (
    .flags        (flags),
    .irq_en       (irq_en),
    .rd_data      (rd_data),
    .irq          (irq),
    .wake_req     (wake_req),
    .deep_idle_ok (deep_idle_ok)
  );
endmodule

// File: rtl/usb_evt_flags_chk.sv
module usb_evt_flags_chk (
  input logic       clk,
  input logic       srst_n,
  input logic       ev_rst_begin,
  input logic       ev_rst_done,
  input logic       ev_resume,
  input logic       wr_en,
  input logic [7:0] wr_data,
  input logic [5:0] irq_en,
  input logic [7:0] rd_data,
  input logic       irq,
  input logic       wake_req,
  input logic       deep_idle_ok
);
  // R1
  always @(posedge clk) if (!srst_n) flags_zero_in_reset_chk: assert (rd_data == 8'h00);

  // R2
  rst_begin_sets_chk: assert property (@(posedge clk) disable iff (!srst_n)
    ev_rst_begin |=> rd_data[7]);

  // R2
  rst_done_sets_chk: assert property (@(posedge clk) disable iff (!srst_n)
    ev_rst_done |=> rd_data[6]);

  // R3
  clear_on_zero_chk: assert property (@(posedge clk) disable iff (!srst_n)
    (wr_en && !wr_data[6] && !ev_rst_done) |=> !rd_data[6]);

  // R5
  low_bits_zero_chk: assert property (@(posedge clk) disable iff (!srst_n)
    rd_data[1:0] == 2'b00);

  // R6
  resume_sets_clkon_chk: assert property (@(posedge clk) disable iff (!srst_n)
    ev_resume |=> rd_data[2]);

  // R8
  sticky_idle_chk: assert property (@(posedge clk) disable iff (!srst_n)
    (rd_data[7] && !wr_en) |=> rd_data[7]);

  // R9
  irq_gate_chk: assert property (@(posedge clk) disable iff (!srst_n)
    irq == |(rd_data[7:2] & irq_en));

  // R10
  wake_any_chk: assert property (@(posedge clk) disable iff (!srst_n)
    wake_req == (rd_data != 8'h00));

  // R11
  deep_idle_chk: assert property (@(posedge clk) disable iff (!srst_n)
    deep_idle_ok == (rd_data[5] | rd_data[3]));
endmodule

bind usb_evt_flags usb_evt_flags_chk i_chk (
  .clk          (clk),
  .srst_n       (srst_n),
  .ev_rst_begin (ev_rst_begin),
  .ev_rst_done  (ev_rst_done),
  .ev_resume    (ev_resume),
  .wr_en        (wr_en),
  .wr_data      (wr_data),
  .irq_en       (irq_en),
  .rd_data      (rd_data),
  .irq          (irq),
  .wake_req     (wake_req),
  .deep_idle_ok (deep_idle_ok)
);

// File: tb/test_usb_evt_flags.sv
`timescale 1ns/1ps
module test_usb_evt_flags;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       ev_rst_begin, ev_rst_done, ev_suspend, ev_resume, ev_clk_stop_ok;
  logic       wr_en;
  logic [7:0] wr_data;
  logic [5:0] irq_en;
  logic [7:0] rd_data;
  logic       irq, wake_req, deep_idle_ok;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #10 clk = ~clk;

  usb_evt_flags i_usb_evt_flags (
    .clk(clk), .rst_n(rst_n),
    .ev_rst_begin(ev_rst_begin), .ev_rst_done(ev_rst_done),
    .ev_suspend(ev_suspend), .ev_resume(ev_resume),
    .ev_clk_stop_ok(ev_clk_stop_ok),
    .wr_en(wr_en), .wr_data(wr_data), .irq_en(irq_en),
    .rd_data(rd_data), .irq(irq), .wake_req(wake_req),
    .deep_idle_ok(deep_idle_ok)
  );

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic idle_inputs();
    ev_rst_begin = 0; ev_rst_done = 0; ev_suspend = 0;
    ev_resume = 0; ev_clk_stop_ok = 0; wr_en = 0; wr_data = 8'h00;
  endtask

  // inputs applied at a negedge are taken at the following posedge;
  // the result is sampled at the negedge after that.
  task automatic step();
    @(negedge clk);
    idle_inputs();
  endtask

  task automatic do_reset();
    idle_inputs();
    irq_en = 6'h00;
    rst_n = 0;
    repeat (3) @(negedge clk);
    check("R1 during reset", rd_data, 8'h00);
    rst_n = 1;
    @(negedge clk);
    check("R1 after release", rd_data, 8'h00);
    repeat (3) @(negedge clk);
  endtask

  task automatic clear_all();
    wr_en = 1; wr_data = 8'h00;
    step();
  endtask

  task automatic t_each_event();
    ev_rst_done = 1; step();
    check("R2 rst_done bit6", rd_data, 8'h40);
    clear_all();
    ev_suspend = 1; step();
    check("R2 suspend bit5", rd_data, 8'h20);
    clear_all();
    ev_clk_stop_ok = 1; step();
    check("R2 clk_stop bit3", rd_data, 8'h08);
    clear_all();
    check("R3 clear all", rd_data, 8'h00);
  endtask

  task automatic t_clkon_causes();
    ev_resume = 1; step();
    check("R6 resume sets bit4 and bit2", rd_data, 8'h14);
    clear_all();
    ev_rst_begin = 1; step();
    check("R6 reset start sets bit7 and bit2", rd_data, 8'h84);
    clear_all();
  endtask

  task automatic t_clear_rules();
    ev_rst_done = 1; ev_suspend = 1; ev_resume = 1; step();
    check("R2 multi", rd_data, 8'h74);
    wr_en = 1; wr_data = 8'hFF; step();
    check("R4 write ones keeps", rd_data, 8'h74);
    wr_en = 1; wr_data = 8'hDF; step();
    check("R3 clear suspend only", rd_data, 8'h54);
    wr_en = 0; wr_data = 8'h00; step(); step();
    check("R8 sticky with wr_en low", rd_data, 8'h54);
    clear_all();
  endtask

  task automatic t_reserved();
    wr_en = 1; wr_data = 8'h03; step();
    check("R5 low bits read zero", rd_data, 8'h00);
    ev_suspend = 1; step();
    wr_en = 1; wr_data = 8'hFC; step();
    check("R5 low-bit zeros do not clear", rd_data, 8'h20);
    clear_all();
  endtask

  task automatic t_collision();
    ev_rst_done = 1; wr_en = 1; wr_data = 8'h00; step();
    check("R7 set beats clear", rd_data, 8'h40);
    clear_all();
  endtask

  task automatic t_outputs();
    check("R10 wake idle", {7'd0, wake_req}, 8'h00);
    check("R11 deep idle off", {7'd0, deep_idle_ok}, 8'h00);
    ev_rst_done = 1; step();
    irq_en = 6'b101111; #1;
    check("R9 masked flag no irq", {7'd0, irq}, 8'h00);
    check("R10 wake ungated", {7'd0, wake_req}, 8'h01);
    irq_en = 6'b010000; #1;
    check("R9 enabled flag irq", {7'd0, irq}, 8'h01);
    check("R11 not suspended", {7'd0, deep_idle_ok}, 8'h00);
    clear_all();
    ev_clk_stop_ok = 1; step();
    check("R11 clk stop allows", {7'd0, deep_idle_ok}, 8'h01);
    irq_en = 6'b000010; #1;
    check("R9 clk stop enabled", {7'd0, irq}, 8'h01);
    clear_all();
    ev_suspend = 1; step();
    check("R11 suspend allows", {7'd0, deep_idle_ok}, 8'h01);
    check("R9 suspend masked", {7'd0, irq}, 8'h00);
    clear_all();
    check("R10 wake drops", {7'd0, wake_req}, 8'h00);
    irq_en = 6'h00;
  endtask

  initial begin
    do_reset();
    t_each_event();
    t_clkon_causes();
    t_clear_rules();
    t_reserved();
    t_collision();
    t_outputs();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule